// File: doc/BRIEF.md
# Dual-Port Offset-7 Shared Register Unit

This unit sits beside a pair of 16550-style UART cores that share one 16-byte I/O window. Port 1 decodes offsets 0 to 7 and port 2 decodes offsets 8 to 15. The unit watches every bus access. It claims the offset-7 location of each port, and it notes bit 7 of every write to offset 3, the line control register, of either port. The UART cores answer all other offsets.

A strap chooses what the offset-7 location holds. With the strap set, offset 7 is a private read/write scratch byte for each port. With the strap clear, both ports expose the same special register, chosen by the latched divisor-latch-access bit:

- A read-only pending-interrupt summary when that bit is 0.
- An options register when that bit is 1.

The options register carries a two-bit identification field that reads back scrambled, and a two-bit clock-rate multiplier field. Two further straps can force the multiplier field. The unit also merges the per-port interrupt requests into one level-sensitive line. It gives the UART baud generators a clock-rate select.

Top module: `duart_aux_regs`

## Requirements
- R1: With `strapScratch` high, a write to offset 7 of a port stores the byte in that port's own scratch register. A read of offset 7 of that port returns the stored byte. The scratch registers of the two ports are independent.
- R2: With `strapScratch` low, bit 7 of the most recent write to offset 3 of either port is latched as the selector. Selector 0 makes offset 7 of both ports return the interrupt summary, and selector 1 makes it return the options register. The selector is 0 after reset.
- R3: The interrupt summary is read-only. Bit 0 is port 1's pending request, bit 1 is port 2's, and bits 7..2 read 0. Writes to it change nothing that is read.
- R4: `irqOut` is high in every cycle in which at least one port's request is high, and low when none is.
- R5: Options register bits 5..2 always read 0, whatever was written to them.
- R6: Options register bits 7..6 hold the identification field. On read, bit 7 returns the AND of the last written bits 7 and 6, and bit 6 returns their XOR. Written 11 reads 10, 10 reads 01, 01 reads 01, and 00 reads 00.
- R7: Options register bits 1..0 hold the multiplier field (bit 1, bit 0). Software can write and read it back. 00 means x1, 10 means x2, 01 means x4, and 11 is treated as x1. `clkSel` reports the multiplier in effect: 0 for x1, 1 for x2, 2 for x4.
- R8: While `strapX2` or `strapX4` is high, the multiplier field reads the strap's code (10 or 01), and `clkSel` follows that code. Software writes to the field are discarded. If both straps are high, x4 wins.
- R9: After reset, every bit of the options register reads 0 and `clkSel` is 0.
- R10: While `strapScratch` is high, writes to offset 7 leave the options register unchanged. Its contents, including the multiplier, reappear once the strap is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Byte offset in the shared window; bit 3 selects the port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for an offset-7 access |
| busHit | output | 1 | The current access targets offset 7, so this unit supplies the data |
| uartIrq | input | 2 | Per-port interrupt requests from the UART cores |
| strapScratch | input | 1 | Strap: offset 7 acts as a per-port scratch byte |
| strapX2 | input | 1 | Strap forcing the x2 multiplier |
| strapX4 | input | 1 | Strap forcing the x4 multiplier |
| irqOut | output | 1 | Shared level-sensitive interrupt |
| clkSel | output | 2 | Effective clock-rate select for the baud generators |

## Verification
The bench builds the unit with its default of two ports. This gives a 4-bit address whose top bit picks the port. It also leaves six unused bits in the interrupt summary, so the read-as-zero upper bits of the summary and the split between the two ports' offset-7 locations are both exercised.

With two ports, the selector can be set through one port and observed through the other, in both directions. The two scratch bytes can be written with different values to show they do not alias. Every strap combination is applied while the options register holds a known software value. This shows that forcing, the priority of x4 over x2, and the restoration of the stored value all take place.

// File: rtl/duart_pkg.sv
package duart_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned OFS_W      = 3;
  localparam logic [2:0]  LCR_OFS    = 3'd3;
  localparam logic [2:0]  SPECIAL_OFS = 3'd7;
  localparam int unsigned DLAB_BIT   = 7;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_SCRATCH = 2'd1,
    SRC_STATUS  = 2'd2,
    SRC_OPTION  = 2'd3
  } rd_src_e;

  typedef enum logic [1:0] {
    CK_X1 = 2'd0,
    CK_X2 = 2'd1,
    CK_X4 = 2'd2
  } clk_sel_e;

  // multiplier field codes (bit 1, bit 0)
  localparam logic [1:0] RR_X1 = 2'b00;
  localparam logic [1:0] RR_X2 = 2'b10;
  localparam logic [1:0] RR_X4 = 2'b01;

  typedef struct packed {
    logic    lcrWr;
    logic    spWr;
    logic    optWr;
    rd_src_e rdSrc;
  } strb_t;

  function automatic int unsigned portBits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned PORT_W = portBits(NUM_PORTS),
  localparam int unsigned ADDR_W = PORT_W + OFS_W
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              strapScratch,
  input  logic              dlabSel,
  output strb_t             strb,
  output logic [PORT_W-1:0] portIdx
);

  logic [OFS_W-1:0] offset;
  logic             portOk;
  logic             acc;

  always_comb begin
    offset  = busAddr[OFS_W-1:0];
    portIdx = busAddr[ADDR_W-1:OFS_W];
    portOk  = (int'(portIdx) < int'(NUM_PORTS));
    acc     = busSel && portOk;

    strb       = '0;
    strb.rdSrc = SRC_NONE;
    if (acc && busWr && offset == LCR_OFS) strb.lcrWr = 1'b1;
    if (acc && offset == SPECIAL_OFS) begin
      if (strapScratch) begin
        strb.rdSrc = SRC_SCRATCH;
        strb.spWr  = busWr;
      end else if (dlabSel) begin
        strb.rdSrc = SRC_OPTION;
        strb.optWr = busWr;
      end else begin
        strb.rdSrc = SRC_STATUS;
      end
    end
  end

endmodule

// File: rtl/duart_dp.sv
module duart_dp
  import duart_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned PORT_W = portBits(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strb_t                strb,
  input  logic [PORT_W-1:0]    portIdx,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_PORTS-1:0] uartIrq,
  input  logic                 strapX2,
  input  logic                 strapX4,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic [1:0]           clkSel,
  output logic                 dlabSel
);

  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'((1 << NUM_PORTS) - 1);

  logic                 dlabQ;
  logic [1:0]           idQ;
  logic [1:0]           rrQ;
  logic [1:0]           effRr;
  logic                 strapOn;
  logic [DATA_W-1:0]    spQ [NUM_PORTS];
  logic [NUM_PORTS-1:0] spWe;
  logic [DATA_W-1:0]    statVec;
  logic [DATA_W-1:0]    optVec;

  // selector latched from any port's line control write
  always_ff @(posedge clk) begin
    if (!rstN)           dlabQ <= 1'b0;
    else if (strb.lcrWr) dlabQ <= busWdata[DLAB_BIT];
  end
  assign dlabSel = dlabQ;

  // per-port scratch bytes
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sp
    assign spWe[p] = strb.spWr && (int'(portIdx) == p);
    always_ff @(posedge clk) begin
      if (!rstN)        spQ[p] <= '0;
      else if (spWe[p]) spQ[p] <= busWdata;
    end
  end

  // options register storage
  assign strapOn = strapX2 | strapX4;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ <= 2'b00;
      rrQ <= RR_X1;
    end else if (strb.optWr) begin
      idQ <= busWdata[7:6];
      if (!strapOn) rrQ <= busWdata[1:0];
    end
  end

  always_comb begin
    if (strapX4)      effRr = RR_X4;
    else if (strapX2) effRr = RR_X2;
    else              effRr = rrQ;
    case (effRr)
      RR_X2:   clkSel = CK_X2;
      RR_X4:   clkSel = CK_X4;
      default: clkSel = CK_X1;
    endcase
  end

  always_comb begin
    statVec = '0;
    for (int i = 0; i < NUM_PORTS; i++) statVec[i] = uartIrq[i];
    optVec = {idQ[1] & idQ[0], idQ[1] ^ idQ[0], 4'b0000, effRr};
    case (strb.rdSrc)
      SRC_SCRATCH: rdData = spQ[portIdx];
      SRC_STATUS:  rdData = statVec;
      SRC_OPTION:  rdData = optVec;
      default:     rdData = '0;
    endcase
  end

  assign irqOut = |uartIrq;

  // R1: at most one scratch byte takes a write in a cycle
  a_r1_single_scratch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(spWe));

  // R2: the selector follows bit 7 of the last line control write
  a_r2_dlab_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.lcrWr |=> (dlabSel == $past(busWdata[DLAB_BIT])));

  // R3: the summary never shows bits above the port count
  a_r3_status_upper: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSrc == SRC_STATUS) |-> ((rdData & ~STAT_MASK) == '0));

  // R5: reserved bits of the options register read 0
  a_r5_opt_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSrc == SRC_OPTION) |-> (rdData[5:2] == 4'b0000));

  // R8: the x4 strap wins over everything
  a_r8_x4_priority: assert property (@(posedge clk) disable iff (!rstN)
    strapX4 |-> (clkSel == CK_X4));

  // R10: scratch mode leaves the identification field untouched
  a_r10_id_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSrc == SRC_SCRATCH) |=> $stable(idQ));

endmodule

// File: rtl/duart_aux_regs.sv
module duart_aux_regs
  import duart_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned PORT_W = portBits(NUM_PORTS),
  localparam int unsigned ADDR_W = PORT_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busHit,
  input  logic [NUM_PORTS-1:0] uartIrq,
  input  logic                 strapScratch,
  input  logic                 strapX2,
  input  logic                 strapX4,
  output logic                 irqOut,
  output logic [1:0]           clkSel
);

  strb_t             strb;
  logic [PORT_W-1:0] portIdx;
  logic              dlabSel;

  duart_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .strapScratch(strapScratch),
    .dlabSel     (dlabSel),
    .strb        (strb),
    .portIdx     (portIdx)
  );

  duart_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .portIdx (portIdx),
    .busWdata(busWdata),
    .uartIrq (uartIrq),
    .strapX2 (strapX2),
    .strapX4 (strapX4),
    .rdData  (busRdata),
    .irqOut  (irqOut),
    .clkSel  (clkSel),
    .dlabSel (dlabSel)
  );

  assign busHit = (strb.rdSrc != SRC_NONE);

  // R4: the shared line is high whenever a request is pending
  a_r4_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    (uartIrq != '0) |-> irqOut);

endmodule

// File: tb/tb_duart_aux_regs.sv
`timescale 1ns/1ps
module tb_duart_aux_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       busHit;
  logic [1:0] uartIrq = 2'b00;
  logic       strapScratch = 1'b0;
  logic       strapX2 = 1'b0;
  logic       strapX4 = 1'b0;
  logic       irqOut;
  logic [1:0] clkSel;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  duart_aux_regs dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busHit(busHit), .uartIrq(uartIrq), .strapScratch(strapScratch),
    .strapX2(strapX2), .strapX4(strapX4), .irqOut(irqOut), .clkSel(clkSel)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // driver: pushes the expected read value, then presents the read
  task automatic busRead(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // monitor: compares offset-7 read data a little after each edge
  always @(posedge clk) begin
    #1;
    if (busSel && !busWr && busAddr[2:0] == 3'd7) begin
      if (expQ.size() == 0) begin
        nChecks++; nErr++;
        $display("FAIL monitor: read with no expected item, actual %02h expected none", busRdata);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(t, busRdata, e);
        chk({t, " hit"}, {7'b0, busHit}, 8'h01);
      end
    end
  end

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    chk("R4 reset irq", {7'b0, irqOut}, 8'h00);
    chk("R9 reset clkSel", {6'b0, clkSel}, 8'h00);
    busRead(4'd7, 8'h00, "R2 reset selects summary");

    // R3 / R4 interrupt summary
    uartIrq = 2'b01; settle();
    chk("R4 irq port1", {7'b0, irqOut}, 8'h01);
    busRead(4'd7, 8'h01, "R3 port1 pending");
    uartIrq = 2'b10; settle();
    chk("R4 irq port2", {7'b0, irqOut}, 8'h01);
    busRead(4'd15, 8'h02, "R3 port2 pending");
    uartIrq = 2'b11;
    busWrite(4'd7, 8'hFF);
    busRead(4'd7, 8'h03, "R3 both pending, write ignored");
    uartIrq = 2'b00; settle();
    chk("R4 irq none", {7'b0, irqOut}, 8'h00);
    busRead(4'd15, 8'h00, "R3 none pending");

    // R2 select options via port 2, R9 reset contents
    busWrite(4'd11, 8'h80);
    busRead(4'd7, 8'h00, "R9 options zero after reset");

    // R6 identification scramble, R5 reserved bits
    busWrite(4'd7, 8'hC0); busRead(4'd7, 8'h80, "R6 write 11");
    busWrite(4'd15, 8'h40); busRead(4'd7, 8'h40, "R6 write 01");
    busWrite(4'd7, 8'h80); busRead(4'd15, 8'h40, "R6 write 10");
    busWrite(4'd7, 8'h00); busRead(4'd7, 8'h00, "R6 write 00");
    busWrite(4'd7, 8'h3C); busRead(4'd7, 8'h00, "R5 reserved read 0");

    // R7 software multiplier
    busWrite(4'd7, 8'h02); busRead(4'd7, 8'h02, "R7 x2 readback");
    chk("R7 clkSel x2", {6'b0, clkSel}, 8'h01);
    busWrite(4'd7, 8'h01); busRead(4'd7, 8'h01, "R7 x4 readback");
    chk("R7 clkSel x4", {6'b0, clkSel}, 8'h02);
    busWrite(4'd7, 8'h03); busRead(4'd7, 8'h03, "R7 code 11 readback");
    chk("R7 clkSel code 11 is x1", {6'b0, clkSel}, 8'h00);
    busWrite(4'd7, 8'h00);

    // R2 selector through port 1, then back
    busWrite(4'd3, 8'h00);
    uartIrq = 2'b10;
    busRead(4'd15, 8'h02, "R2 port1 lcr clears selector");
    uartIrq = 2'b00;
    busWrite(4'd3, 8'h83);
    busRead(4'd15, 8'h00, "R2 port1 lcr sets selector");

    // R8 straps
    strapX2 = 1'b1; settle();
    chk("R8 clkSel x2 strap", {6'b0, clkSel}, 8'h01);
    busRead(4'd7, 8'h02, "R8 x2 strap read");
    busWrite(4'd7, 8'h01);
    busRead(4'd7, 8'h02, "R8 write ignored under strap");
    strapX4 = 1'b1; settle();
    chk("R8 both straps x4 wins", {6'b0, clkSel}, 8'h02);
    busRead(4'd7, 8'h01, "R8 both straps read");
    strapX2 = 1'b0;
    busRead(4'd7, 8'h01, "R8 x4 strap read");
    strapX4 = 1'b0; settle();
    chk("R8 strap removed clkSel", {6'b0, clkSel}, 8'h00);
    busRead(4'd7, 8'h00, "R8 stored field kept");

    // R1 scratch mode, R10 options preserved
    busWrite(4'd7, 8'h42);
    busRead(4'd7, 8'h42, "R10 options before scratch");
    strapScratch = 1'b1;
    busWrite(4'd7, 8'h5A);
    busWrite(4'd15, 8'hA5);
    busRead(4'd7, 8'h5A, "R1 port1 scratch");
    busRead(4'd15, 8'hA5, "R1 port2 scratch");
    busWrite(4'd7, 8'hFF);
    busRead(4'd15, 8'hA5, "R1 port2 independent");
    busRead(4'd7, 8'hFF, "R1 port1 rewrite");
    chk("R10 clkSel kept in scratch mode", {6'b0, clkSel}, 8'h01);
    strapScratch = 1'b0;
    busRead(4'd7, 8'h42, "R10 options unchanged");

    // R9 reset again mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    settle();
    chk("R9 clkSel after reset", {6'b0, clkSel}, 8'h00);
    busRead(4'd7, 8'h00, "R2 selector cleared by reset");
    busWrite(4'd3, 8'h80);
    busRead(4'd7, 8'h00, "R9 options cleared by reset");

    settle();
    if (expQ.size() != 0) begin
      nChecks++; nErr++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule